// File: doc/BRIEF.md
# Host-Port Burst Writer

This block moves fixed-length blocks of receiver samples from fabric logic into a signal processor's memory through a 16-bit host-port style bus. Samples arrive on a plain valid/data stream and collect in an internal FIFO. When a full block is buffered and the processor raises its host-interrupt line, the block runs one burst. It acknowledges the interrupt, loads a target address and streams the block. It then writes a notify word, polls the processor's control register until a busy bit clears, writes a clear word, and waits for the interrupt line to drop before it goes back to idle.

Every bus phase carries a 2-bit register-select code and a read/write level. A strobe marks each word offered on the bus. A word counts as taken only on a clock where the strobe is high and the synchronized ready line is high. Successive bursts target two buffer addresses in turn, so the processor can work on one buffer while the other fills. The host-interrupt and ready lines are asynchronous and pass through two-flop synchronizers.

Top module: `hpi_burst_writer`

## Requirements
- R1: While the synchronous active-high reset is high, the block holds a known idle state: `busy_o`, `done_o`, `hstb_o`, `hrw_o` and `hd_oe_o` are 0, `hctl_o` is 00, and the first buffer address is selected for the next burst.
- R2: In idle, the strobe is low and `hctl_o` is 00. A burst starts only when the synchronized interrupt is 1 and the FIFO holds at least BURST_LEN words. With fewer words buffered, a raised interrupt has no effect.
- R3: The first phase of a burst writes the value 4 with select code 10 and `hrw_o` low. The next phase writes the target address with select code 01.
- R4: The address phase carries ADDR_A in the first burst after reset and then ADDR_B and ADDR_A in turn (defaults 0x0000 and 0x0100).
- R5: The data phase offers exactly BURST_LEN words (256 by default) with select code 01 and `hrw_o` low, in arrival order. It then goes on to the notify phase.
- R6: While a word is offered and the synchronized ready is 0, the word is held: the strobe stays high and the select code, read/write level and data stay unchanged.
- R7: The notify phase writes the value 2 with select code 10. It then reads with select code 11 and `hrw_o` high, with the data bus released (`hd_oe_o` low). It repeats the read while bit 1 of `hd_i` is 1 and leaves when that bit reads 0.
- R8: The final phase writes the value 4 with select code 10. It then holds the strobe low and returns to idle once the synchronized interrupt is 0.
- R9: Interrupt and ready changes take effect through a two-stage synchronizer. A rising interrupt that meets a full FIFO makes `busy_o` rise after the third rising clock edge.
- R10: `busy_o` is high from the clock that leaves idle until the clock that returns to it. `done_o` is a one-cycle pulse in the first idle cycle after each completed burst.
- R11: Words presented while the FIFO already holds FIFO_DEPTH words are dropped and never appear on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample word present on `in_data` |
| in_data | input | DW | Sample word |
| hint_i | input | 1 | Host-interrupt level from the processor (asynchronous) |
| hrdy_i | input | 1 | Ready level from the processor (asynchronous) |
| hd_i | input | DW | Read data from the processor's bus |
| hctl_o | output | 2 | Register-select code of the current phase |
| hrw_o | output | 1 | 1 = read, 0 = write |
| hstb_o | output | 1 | A word is offered in this cycle |
| hd_o | output | DW | Write data (0 when not driven) |
| hd_oe_o | output | 1 | Output enable of the data bus; 0 = high impedance |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse on burst completion |

## Verification
The bench stalls the ready line in a repeating pattern during a burst. A design that advanced on a stalled word, or that took ready without synchronizing it, would skip or repeat samples, and the per-cycle comparison catches that. The bench overfills the FIFO before the first burst and checks the last streamed word. A design that overwrote the oldest word or kept the extra words would show the wrong final word, or would leave stray words that break the next burst. The bench holds the busy bit set for several polls and raises the interrupt while the FIFO is short of a block. A design that stopped polling too early, or that started early, would leave the reference sequence. Three bursts check the address order, and a timed interrupt edge checks the synchronizer depth.

// File: rtl/hpi_bw_pkg.sv
`timescale 1ns/1ps
package hpi_bw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACK,
      ST_ADDR,
      ST_DATA,
      ST_NOTIFY,
      ST_RELEASE
   } hpi_state_e;

   localparam logic [1:0] SEL_NONE = 2'b00;
   localparam logic [1:0] SEL_ADDR = 2'b01;
   localparam logic [1:0] SEL_CTRL = 2'b10;
   localparam logic [1:0] SEL_STAT = 2'b11;
endpackage

// File: rtl/hpi_bw_sync.sv
`timescale 1ns/1ps
module hpi_bw_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hpi_bw_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hpi_bw_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (rst) stg_q <= '0;
      else     stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hpi_bw_fifo.sv
`timescale 1ns/1ps
module hpi_bw_fifo #(
   parameter int W      = 16,
   parameter int DEPTH  = 256,
   parameter int THRESH = 256
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push_valid,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         block_avail
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] LVL_BLK  = LVL_W'(THRESH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hpi_bw_fifo: DEPTH must be at least 2");
      end
      if (THRESH > DEPTH || THRESH < 1) begin : g_bad_thresh
         $error("hpi_bw_fifo: THRESH must lie in 1..DEPTH");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] level;
   logic             full, wr_en;

   assign full  = (level == LVL_FULL);
   assign wr_en = push_valid && !full;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
         if (pop)   rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
         case ({wr_en, pop})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end

   assign head        = mem[rd_ptr];
   assign block_avail = (level >= LVL_BLK);

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
      pop |-> (level != '0));

   assert_full_drop_R11: assert property (@(posedge clk) disable iff (rst)
      (push_valid && full && !pop) |=> (level == $past(level)));
endmodule

// File: rtl/hpi_bw_fsm.sv
`timescale 1ns/1ps
module hpi_bw_fsm
   import hpi_bw_pkg::*;
#(
   parameter int            DW        = 16,
   parameter int            BURST_LEN = 256,
   parameter logic [DW-1:0] ADDR_A    = '0,
   parameter logic [DW-1:0] ADDR_B    = '0,
   parameter logic [DW-1:0] BUSY_MASK = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hint_s,
   input  logic          rdy_s,
   input  logic          blk_avail,
   input  logic [DW-1:0] sample,
   input  logic [DW-1:0] rd_data,
   output logic          pop,
   output logic [1:0]    hctl,
   output logic          hrw,
   output logic          hstb,
   output logic [DW-1:0] hd,
   output logic          hd_oe,
   output logic          busy,
   output logic          done
);
   localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam logic [CW-1:0] CNT_LAST   = CW'(BURST_LEN - 1);
   localparam logic [DW-1:0] ACK_WORD   = DW'(4);
   localparam logic [DW-1:0] NOTIFY_WRD = DW'(2);

   generate
      if (BURST_LEN < 2) begin : g_bad_len
         $error("hpi_bw_fsm: BURST_LEN must be at least 2");
      end
      if (DW < 3) begin : g_bad_dw
         $error("hpi_bw_fsm: DW must be at least 3");
      end
   endgenerate

   hpi_state_e    state_q, state_d;
   logic          phase_q, phase_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          sel_q, sel_d;
   logic          done_q, done_d;
   logic          accept;

   assign accept = hstb && rdy_s;

   always_comb begin
      hstb  = 1'b0;
      hd_oe = 1'b0;
      hctl  = SEL_NONE;
      hrw   = 1'b0;
      hd    = '0;
      case (state_q)
         ST_ACK: begin
            hstb = 1'b1; hd_oe = 1'b1; hctl = SEL_CTRL; hd = ACK_WORD;
         end
         ST_ADDR: begin
            hstb = 1'b1; hd_oe = 1'b1; hctl = SEL_ADDR;
            hd   = sel_q ? ADDR_B : ADDR_A;
         end
         ST_DATA: begin
            hstb = 1'b1; hd_oe = 1'b1; hctl = SEL_ADDR; hd = sample;
         end
         ST_NOTIFY: begin
            hstb = 1'b1;
            if (!phase_q) begin
               hd_oe = 1'b1; hctl = SEL_CTRL; hd = NOTIFY_WRD;
            end else begin
               hctl = SEL_STAT; hrw = 1'b1;
            end
         end
         ST_RELEASE: begin
            if (!phase_q) begin
               hstb = 1'b1; hd_oe = 1'b1; hctl = SEL_CTRL; hd = ACK_WORD;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      state_d = state_q;
      phase_d = phase_q;
      cnt_d   = cnt_q;
      sel_d   = sel_q;
      done_d  = 1'b0;
      pop     = 1'b0;
      case (state_q)
         ST_IDLE: if (hint_s && blk_avail) begin
            state_d = ST_ACK;
            phase_d = 1'b0;
         end
         ST_ACK: if (accept) state_d = ST_ADDR;
         ST_ADDR: if (accept) begin
            state_d = ST_DATA;
            cnt_d   = '0;
         end
         ST_DATA: if (accept) begin
            pop = 1'b1;
            if (cnt_q == CNT_LAST) begin
               state_d = ST_NOTIFY;
               phase_d = 1'b0;
            end else begin
               cnt_d = cnt_q + CW'(1);
            end
         end
         ST_NOTIFY: if (accept) begin
            if (!phase_q) phase_d = 1'b1;
            else if ((rd_data & BUSY_MASK) == '0) begin
               state_d = ST_RELEASE;
               phase_d = 1'b0;
            end
         end
         ST_RELEASE: begin
            if (!phase_q) begin
               if (accept) phase_d = 1'b1;
            end else if (!hint_s) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
               sel_d   = ~sel_q;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         phase_q <= 1'b0;
         cnt_q   <= '0;
         sel_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         sel_q   <= sel_d;
         done_q  <= done_d;
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;

   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (hstb && !rdy_s) |=> (hstb && $stable(hctl) && $stable(hrw) && $stable(hd)));

   assert_poll_repeat_R7: assert property (@(posedge clk) disable iff (rst)
      (hrw && accept && ((rd_data & BUSY_MASK) != '0)) |=> hrw);

   assert_read_release_R7: assert property (@(posedge clk) disable iff (rst)
      hrw |-> !hd_oe);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
endmodule

// File: rtl/hpi_burst_writer.sv
`timescale 1ns/1ps
module hpi_burst_writer #(
   parameter int            DW          = 16,
   parameter int            BURST_LEN   = 256,
   parameter int            FIFO_DEPTH  = 256,
   parameter int            SYNC_STAGES = 2,
   parameter logic [DW-1:0] ADDR_A      = 16'h0000,
   parameter logic [DW-1:0] ADDR_B      = 16'h0100,
   parameter logic [DW-1:0] BUSY_MASK   = 16'h0002
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          hint_i,
   input  logic          hrdy_i,
   input  logic [DW-1:0] hd_i,
   output logic [1:0]    hctl_o,
   output logic          hrw_o,
   output logic          hstb_o,
   output logic [DW-1:0] hd_o,
   output logic          hd_oe_o,
   output logic          busy_o,
   output logic          done_o
);
   generate
      if (FIFO_DEPTH < BURST_LEN) begin : g_bad_fifo
         $error("hpi_burst_writer: FIFO_DEPTH must hold one burst");
      end
   endgenerate

   logic [1:0]    sync_q;
   logic          pop;
   logic          blk_avail;
   logic [DW-1:0] head;

   hpi_bw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({hint_i, hrdy_i}),
      .q   (sync_q)
   );

   hpi_bw_fifo #(.W(DW), .DEPTH(FIFO_DEPTH), .THRESH(BURST_LEN)) u_fifo (
      .clk         (clk),
      .rst         (rst),
      .push_valid  (in_valid),
      .push_data   (in_data),
      .pop         (pop),
      .head        (head),
      .block_avail (blk_avail)
   );

   hpi_bw_fsm #(
      .DW        (DW),
      .BURST_LEN (BURST_LEN),
      .ADDR_A    (ADDR_A),
      .ADDR_B    (ADDR_B),
      .BUSY_MASK (BUSY_MASK)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .hint_s    (sync_q[1]),
      .rdy_s     (sync_q[0]),
      .blk_avail (blk_avail),
      .sample    (head),
      .rd_data   (hd_i),
      .pop       (pop),
      .hctl      (hctl_o),
      .hrw       (hrw_o),
      .hstb      (hstb_o),
      .hd        (hd_o),
      .hd_oe     (hd_oe_o),
      .busy      (busy_o),
      .done      (done_o)
   );
endmodule

// File: tb/hpi_burst_writer_tb_top.sv
`timescale 1ns/1ps
module hpi_burst_writer_tb_top;
   localparam int          BL    = 256;
   localparam int          DEPTH = 256;
   localparam logic [15:0] A0    = 16'h0000;
   localparam logic [15:0] A1    = 16'h0100;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        hint = 1'b0;
   logic        rdy = 1'b1;
   logic [15:0] hd_i = 16'h0002;
   logic [1:0]  hctl;
   logic        hrw, hstb, hd_oe, busy, done;
   logic [15:0] hd;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   hpi_burst_writer dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .hint_i(hint), .hrdy_i(rdy), .hd_i(hd_i),
      .hctl_o(hctl), .hrw_o(hrw), .hstb_o(hstb), .hd_o(hd),
      .hd_oe_o(hd_oe), .busy_o(busy), .done_o(done)
   );

   // behavioural reference
   int          ms = 0;
   bit          mph, msel, mdone;
   int          mcnt;
   bit          s0h, s1h, s0r, s1r;
   logic [15:0] q[$];
   int          bursts = 0;
   int          old_size;
   bit          acc;
   logic [15:0] addr_seen [3];
   logic [15:0] last_seen = '0;
   int          done_seen = 0;
   bit          stall_en = 1'b0;

   function automatic bit m_strobe();
      if (ms == 0) return 1'b0;
      if (ms == 5) return !mph;
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         ms = 0; mph = 0; mcnt = 0; msel = 0; mdone = 0;
         s0h = 0; s1h = 0; s0r = 0; s1r = 0;
         q.delete();
      end else begin
         old_size = q.size();
         acc = m_strobe() && s1r;
         mdone = 0;
         case (ms)
            0: if (s1h && old_size >= BL) begin ms = 1; mph = 0; end
            1: if (acc) ms = 2;
            2: if (acc) begin ms = 3; mcnt = 0; end
            3: if (acc) begin
                  void'(q.pop_front());
                  if (mcnt == BL - 1) begin ms = 4; mph = 0; end
                  else mcnt++;
               end
            4: if (acc) begin
                  if (!mph) mph = 1;
                  else if ((hd_i & 16'h0002) == 0) begin ms = 5; mph = 0; end
               end
            default: begin
               if (!mph) begin
                  if (acc) mph = 1;
               end else if (!s1h) begin
                  ms = 0; mdone = 1; msel = !msel; bursts++;
               end
            end
         endcase
         s1h = s0h; s0h = hint; s1r = s0r; s0r = rdy;
         if (in_valid && old_size < DEPTH) q.push_back(in_data);
      end
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison: {busy,done,stb,ctl,rw,oe,data}
   logic [22:0] exp_v, act_v;
   logic [15:0] exp_d;
   string       tag;
   always @(negedge clk) begin
      if (!rst) begin
         exp_d = '0;
         case (ms)
            1: exp_d = 16'd4;
            2: exp_d = msel ? A1 : A0;
            3: exp_d = q[0];
            4: exp_d = mph ? 16'd0 : 16'd2;
            5: exp_d = mph ? 16'd0 : 16'd4;
            default: exp_d = '0;
         endcase
         exp_v = {ms != 0, mdone, m_strobe(),
                  (ms == 1 || (ms == 4 && !mph) || (ms == 5 && !mph)) ? 2'b10 :
                  (ms == 2 || ms == 3) ? 2'b01 : (ms == 4) ? 2'b11 : 2'b00,
                  ms == 4 && mph,
                  m_strobe() && !(ms == 4 && mph), exp_d};
         act_v = {busy, done, hstb, hctl, hrw, hd_oe, hd_oe ? hd : 16'h0};
         if (act_v[22:21] != exp_v[22:21]) tag = "R10";
         else if (m_strobe() && !s1r) tag = "R6";
         else case (ms)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R4";
            3: tag = "R5";
            4: tag = "R7";
            default: tag = "R8";
         endcase
         check(act_v == exp_v, tag, {9'd0, act_v}, {9'd0, exp_v});
         if (ms == 2 && bursts < 3) addr_seen[bursts] = hd;
         if (ms == 3 && mcnt == BL - 1) last_seen = hd;
         if (done) done_seen++;
      end
   end

   // ready stall pattern
   initial begin
      int k = 0;
      forever begin
         @(negedge clk);
         k++;
         if (stall_en) rdy = ((k % 5) != 2) && ((k % 11) != 7);
         else          rdy = 1'b1;
      end
   end

   task automatic push_words(input logic [15:0] base, input int n, input bit gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); in_valid = 1'b1; in_data = base + 16'(i);
         if (gap) begin @(negedge clk); in_valid = 1'b0; end
      end
      @(negedge clk); in_valid = 1'b0;
   endtask

   task automatic run_burst();
      @(negedge clk); hint = 1'b1;
      @(negedge clk); check(busy == 1'b0, "R9", {31'd0, busy}, 32'd0);
      @(negedge clk); check(busy == 1'b0, "R9", {31'd0, busy}, 32'd0);
      @(negedge clk); check(busy == 1'b1, "R9", {31'd0, busy}, 32'd1);
      while (!(ms == 4 && mph)) @(negedge clk);
      repeat (4) @(negedge clk);
      hd_i = 16'h0000;
      while (!(ms == 5 && mph)) @(negedge clk);
      repeat (3) @(negedge clk);
      hint = 1'b0;
      while (ms != 0) @(negedge clk);
      @(negedge clk); hd_i = 16'h0002;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({busy, done, hstb, hctl, hrw, hd_oe} == 7'd0, "R1",
            {25'd0, busy, done, hstb, hctl, hrw, hd_oe}, 32'd0);
      rst = 1'b0;
      // R2: interrupt with no full block must not start
      @(negedge clk); hint = 1'b1;
      repeat (10) @(negedge clk);
      check(busy == 1'b0 && hstb == 1'b0, "R2", {30'd0, busy, hstb}, 32'd0);
      hint = 1'b0;
      repeat (4) @(negedge clk);
      // burst 1 with overfill (R11)
      push_words(16'h1000, BL, 1'b0);
      push_words(16'hDEA0, 4, 1'b0);
      run_burst();
      check(last_seen == 16'h10FF, "R11", {16'd0, last_seen}, 32'h10FF);
      check(done_seen == 1, "R10", done_seen, 1);
      // burst 2 with ready stalls and concurrent refill
      push_words(16'h2000, BL, 1'b0);
      stall_en = 1'b1;
      fork
         run_burst();
         begin repeat (20) @(negedge clk); push_words(16'h3000, BL, 1'b1); end
      join
      stall_en = 1'b0;
      repeat (4) @(negedge clk);
      run_burst();
      check(done_seen == 3, "R10", done_seen, 3);
      check(addr_seen[0] == A0, "R4", {16'd0, addr_seen[0]}, {16'd0, A0});
      check(addr_seen[1] == A1, "R4", {16'd0, addr_seen[1]}, {16'd0, A1});
      check(addr_seen[2] == A0, "R4", {16'd0, addr_seen[2]}, {16'd0, A0});
      check(q.size() == 0 && busy == 1'b0, "R5", {31'd0, busy}, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R2: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule